// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns pin activity on general-purpose input ports into interrupt requests. Sixteen lines are provided. Each line watches one pin: line n looks at pin n of a port chosen by a 4-bit select field. The raw port vectors are first brought into the block's clock domain. Each line can then record rising edges, falling edges, or both, as its per-line enables allow.

Rising events and falling events latch into two separate sticky pending registers. Software clears either register by writing 1. A software-trigger register lets firmware set a line's pending state directly, as if an edge had occurred. A per-line mask decides which pending lines reach the outputs. The outputs are seven interrupt requests in a fixed grouping: five of them serve a single line each, and the other two serve the upper lines in shared groups.

Software reaches the block through a plain synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `xline_irq`

## Requirements
- R1: After reset, all registers, pending flags and select fields are zero, every interrupt output is low, and every readable address returns 0.
- R2: Word addresses are as follows:
  - 0 is the mask.
  - 1 is the rising enable.
  - 2 is the falling enable.
  - 3 is the software trigger, which always reads 0.
  - 4 is the rising pending register.
  - 5 is the falling pending register.
  - 6 to 9 are the port selects.
  - For addresses 0 to 5, bit n holds line n, and bits 31:16 read as 0 whatever was written.
- R3: A level change on a line's selected pin is seen only through two synchronizing flops. If the new level is present before clock edge k, the matching pending bit reads set after edge k+2 and not before.
- R4: Rising and falling enables are independent per line. With only one of them set, the opposite edge latches nothing. With both set, each edge latches.
- R5: Rising events latch in the rising pending register and falling events latch in the falling pending register. A line counts as pending when either of its two bits is set.
- R6: Writing 1 to a bit of a pending register clears that bit. Writing 0 leaves the bit unchanged.
- R7: If a hardware edge and a write-1-to-clear of the same bit land on the same clock edge, the bit ends up set.
- R8: Writing 1 to bit n of the software trigger sets bit n of the rising pending register, whatever that line's edge enables are.
- R9: A line drives its output only while its mask bit is 1. Clearing a mask bit leaves both pending bits intact.
- R10: Output grouping is fixed:
  - Outputs 0 to 4 follow lines 0 to 4, one line each.
  - Output 5 serves lines 5 to 9.
  - Output 6 serves lines 10 to 15.
  - An output is high while any of its member lines is pending and unmasked.
- R11: Line n samples GPIO input bit (select × 16 + n). Its select field sits in the register at address 6 + n/4, at bits [8×(n mod 4)+3 : 8×(n mod 4)]. All other bits of the select registers read as 0.
- R12: Changing a line's select never produces an edge by itself. Only a later change of the newly selected pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| gpioIn | input | 256 | Sixteen 16-bit GPIO ports, port p on bits [16p+15:16p] |
| irqOut | output | 7 | Grouped interrupt requests |

## Verification
The hardest situation to reach from the ports is a write-1-to-clear that lands on the very clock edge at which a synchronized edge latches. The bench counts the two synchronizer stages from the negative edge where the pin changes, and schedules the clear write so that it is sampled on the third rising edge. The second awkward situation is a select change at a moment when the old and new pins differ in level. The bench parks opposite levels on the two pins first and lets them settle through the synchronizer before it rewrites the select. A behavioural model tracks every cycle, so any stray pending bit appears at once on the read port or the outputs.

// File: rtl/xline_pkg.sv
package xline_pkg;
  localparam int NUM_LINES = 16;
  localparam int NUM_IRQ   = 7;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int SEL_W     = 4;
  localparam int LINES_PER_SEL = 4;
  localparam int SEL_REGS  = NUM_LINES / LINES_PER_SEL;

  localparam logic [ADDR_W-1:0] A_MASK  = 4'd0;
  localparam logic [ADDR_W-1:0] A_RISE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_FALL  = 4'd2;
  localparam logic [ADDR_W-1:0] A_SWI   = 4'd3;
  localparam logic [ADDR_W-1:0] A_PENDR = 4'd4;
  localparam logic [ADDR_W-1:0] A_PENDF = 4'd5;
  localparam logic [ADDR_W-1:0] A_SEL0  = 4'd6;

  typedef struct packed {
    logic                wrMask;
    logic                wrRiseEn;
    logic                wrFallEn;
    logic                swTrig;
    logic                clrRise;
    logic                clrFall;
    logic [SEL_REGS-1:0] wrSel;
  } strobe_t;
endpackage

// File: rtl/xline_ctrl.sv
module xline_ctrl
  import xline_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '0;
    if (wrEn) begin
      unique case (addr)
        A_MASK:  strobe.wrMask   = 1'b1;
        A_RISE:  strobe.wrRiseEn = 1'b1;
        A_FALL:  strobe.wrFallEn = 1'b1;
        A_SWI:   strobe.swTrig   = 1'b1;
        A_PENDR: strobe.clrRise  = 1'b1;
        A_PENDF: strobe.clrFall  = 1'b1;
        default: ;
      endcase
      for (int k = 0; k < SEL_REGS; k++)
        if (addr == ADDR_W'(int'(A_SEL0) + k)) strobe.wrSel[k] = 1'b1;
    end
  end
endmodule

// File: rtl/xline_dp.sv
module xline_dp
  import xline_pkg::*;
#(
  parameter int NUM_PORTS     = 16,
  parameter int PINS_PER_PORT = 16,
  localparam int GPIO_W       = NUM_PORTS * PINS_PER_PORT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [GPIO_W-1:0]    gpioIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_IRQ-1:0]   irqOut,
  output logic [NUM_LINES-1:0] pendRise,
  output logic [NUM_LINES-1:0] pendFall,
  output logic [NUM_LINES-1:0] maskOut
);
  localparam int PAD_W = DATA_W - NUM_LINES;

  logic [GPIO_W-1:0]    syncA, syncB;
  logic [NUM_LINES-1:0] maskQ, riseEnQ, fallEnQ, pendRiseQ, pendFallQ, prevQ;
  logic [NUM_LINES-1:0][SEL_W-1:0] selQ;
  logic [NUM_LINES-1:0] riseEv, fallEv, prevNext, active;
  logic [NUM_LINES-1:0] wrLow, clrRiseMask, clrFallMask, swMask;

  function automatic logic pickPin(input logic [GPIO_W-1:0] v,
                                   input logic [SEL_W-1:0] s, input int line);
    logic b;
    b = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (s == SEL_W'(p)) b = v[p*PINS_PER_PORT + line];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= gpioIn;
      syncB <= syncA;
    end
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [SEL_W-1:0] selNew;
    logic selChg, curBit;
    assign selNew = strobe.wrSel[n/LINES_PER_SEL]
                  ? wrData[8*(n%LINES_PER_SEL) +: SEL_W] : selQ[n];
    assign selChg = (selNew != selQ[n]);
    assign curBit = pickPin(syncB, selQ[n], n);
    assign riseEv[n]   = !selChg &&  curBit && !prevQ[n] && riseEnQ[n];
    assign fallEv[n]   = !selChg && !curBit &&  prevQ[n] && fallEnQ[n];
    assign prevNext[n] = selChg ? pickPin(syncB, selNew, n) : curBit;
  end

  assign wrLow       = wrData[NUM_LINES-1:0];
  assign clrRiseMask = strobe.clrRise ? wrLow : '0;
  assign clrFallMask = strobe.clrFall ? wrLow : '0;
  assign swMask      = strobe.swTrig  ? wrLow : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      riseEnQ   <= '0;
      fallEnQ   <= '0;
      pendRiseQ <= '0;
      pendFallQ <= '0;
      prevQ     <= '0;
      selQ      <= '0;
    end else begin
      prevQ     <= prevNext;
      pendRiseQ <= (pendRiseQ & ~clrRiseMask) | riseEv | swMask;
      pendFallQ <= (pendFallQ & ~clrFallMask) | fallEv;
      if (strobe.wrMask)   maskQ   <= wrLow;
      if (strobe.wrRiseEn) riseEnQ <= wrLow;
      if (strobe.wrFallEn) fallEnQ <= wrLow;
      for (int n = 0; n < NUM_LINES; n++)
        if (strobe.wrSel[n/LINES_PER_SEL])
          selQ[n] <= wrData[8*(n%LINES_PER_SEL) +: SEL_W];
    end
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      A_MASK:  rdData = {{PAD_W{1'b0}}, maskQ};
      A_RISE:  rdData = {{PAD_W{1'b0}}, riseEnQ};
      A_FALL:  rdData = {{PAD_W{1'b0}}, fallEnQ};
      A_PENDR: rdData = {{PAD_W{1'b0}}, pendRiseQ};
      A_PENDF: rdData = {{PAD_W{1'b0}}, pendFallQ};
      default: begin
        for (int k = 0; k < SEL_REGS; k++)
          if (addr == ADDR_W'(int'(A_SEL0) + k))
            for (int j = 0; j < LINES_PER_SEL; j++)
              rdData[8*j +: SEL_W] = selQ[k*LINES_PER_SEL + j];
      end
    endcase
  end

  assign active = (pendRiseQ | pendFallQ) & maskQ;

  for (genvar g = 0; g < 5; g++) begin : g_solo
    assign irqOut[g] = active[g];
  end
  assign irqOut[5] = |active[9:5];
  assign irqOut[6] = |active[15:10];

  assign pendRise = pendRiseQ;
  assign pendFall = pendFallQ;
  assign maskOut  = maskQ;
endmodule

// File: rtl/xline_irq.sv
module xline_irq
  import xline_pkg::*;
#(
  parameter int NUM_PORTS     = 16,
  parameter int PINS_PER_PORT = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                wrEn,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wrData,
  output logic [DATA_W-1:0]                   rdData,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0]  gpioIn,
  output logic [NUM_IRQ-1:0]                  irqOut
);
  strobe_t              strobe;
  logic [NUM_LINES-1:0] pendRiseW, pendFallW, maskW;

  xline_ctrl u_ctrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strobe (strobe)
  );

  xline_dp #(
    .NUM_PORTS     (NUM_PORTS),
    .PINS_PER_PORT (PINS_PER_PORT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .wrData   (wrData),
    .gpioIn   (gpioIn),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .pendRise (pendRiseW),
    .pendFall (pendFallW),
    .maskOut  (maskW)
  );
endmodule

// File: rtl/xline_irq_chk.sv
module xline_irq_chk
  import xline_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_IRQ-1:0]   irqOut,
  input logic [NUM_LINES-1:0] pendRise,
  input logic [NUM_LINES-1:0] pendFall,
  input logic [NUM_LINES-1:0] maskQ
);
  logic [NUM_LINES-1:0] pendAll;
  logic [NUM_IRQ-1:0]   expIrq;
  assign pendAll = pendRise | pendFall;

  always_comb begin
    expIrq = '0;
    for (int n = 0; n < NUM_LINES; n++)
      if (pendAll[n] && maskQ[n])
        expIrq[(n < 5) ? n : ((n < 10) ? 5 : 6)] = 1'b1;
  end

  p_group_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> irqOut == expIrq);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == A_PENDR || addr == A_PENDF))
      |=> (pendAll & $past(pendAll)) == $past(pendAll));

  p_swset_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SWI)
      |=> (pendRise & $past(wrData[NUM_LINES-1:0])) == $past(wrData[NUM_LINES-1:0]));

  p_hizero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (addr < A_SEL0) |-> rdData[DATA_W-1:NUM_LINES] == '0);

  p_selpad_r11: assert property (@(posedge clk) disable iff (!rstN)
    (addr >= A_SEL0 && addr < A_SEL0 + 4'd4) |-> (rdData & 32'hF0F0_F0F0) == '0);
endmodule

bind xline_irq xline_irq_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .irqOut   (irqOut),
  .pendRise (pendRiseW),
  .pendFall (pendFallW),
  .maskQ    (maskW)
);

// File: tb/sim_xline_irq.sv
`timescale 1ns/1ps
module sim_xline_irq;
  localparam int NP = 16;
  localparam int PP = 16;
  localparam int GW = NP * PP;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [GW-1:0] gpioIn = '0;
  logic [6:0]    irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  xline_irq u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
                .rdData(rdData), .gpioIn(gpioIn), .irqOut(irqOut));

  always #2 clk = ~clk;

  // behavioural reference model
  bit [GW-1:0] m1, m2;
  bit [15:0] mMask, mRise, mFall, mPR, mPF, mPrev;
  int mSel[16];

  function automatic bit pinAt(int sel, int line);
    if (sel >= NP) return 1'b0;
    return m2[sel*PP + line];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 = '0; m2 = '0; mMask = 0; mRise = 0; mFall = 0;
      mPR = 0; mPF = 0; mPrev = 0;
      for (int n = 0; n < 16; n++) mSel[n] = 0;
    end else begin
      bit [15:0] nPR, nPF, nPrev, d;
      int nSel[16];
      d = wrData[15:0];
      nPR = mPR; nPF = mPF;
      if (wrEn && addr == 4) nPR = nPR & ~d;
      if (wrEn && addr == 5) nPF = nPF & ~d;
      if (wrEn && addr == 3) nPR = nPR | d;
      for (int n = 0; n < 16; n++) begin
        bit cur, chg;
        nSel[n] = mSel[n];
        if (wrEn && int'(addr) == 6 + n/4) nSel[n] = (wrData >> (8*(n%4))) & 15;
        chg = (nSel[n] != mSel[n]);
        cur = pinAt(mSel[n], n);
        if (!chg && cur && !mPrev[n] && mRise[n]) nPR[n] = 1'b1;
        if (!chg && !cur && mPrev[n] && mFall[n]) nPF[n] = 1'b1;
        nPrev[n] = chg ? pinAt(nSel[n], n) : cur;
      end
      if (wrEn && addr == 0) mMask = d;
      if (wrEn && addr == 1) mRise = d;
      if (wrEn && addr == 2) mFall = d;
      mPR = nPR; mPF = nPF; mPrev = nPrev;
      for (int n = 0; n < 16; n++) mSel[n] = nSel[n];
      m2 = m1; m1 = gpioIn;
    end
  end

  function automatic logic [31:0] modelRead(logic [3:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      0: v[15:0] = mMask;
      1: v[15:0] = mRise;
      2: v[15:0] = mFall;
      4: v[15:0] = mPR;
      5: v[15:0] = mPF;
      6, 7, 8, 9:
        for (int j = 0; j < 4; j++) v[8*j +: 4] = 4'(mSel[(int'(a) - 6)*4 + j]);
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [6:0] modelIrq();
    logic [6:0] o;
    bit [15:0] act;
    act = (mPR | mPF) & mMask;
    o = '0;
    for (int n = 0; n < 16; n++)
      if (act[n]) begin
        if (n < 5) o[n] = 1'b1;
        else if (n < 10) o[5] = 1'b1;
        else o[6] = 1'b1;
      end
    return o;
  endfunction

  task automatic expect32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      expect32("R10 model irqOut", 32'(irqOut), 32'(modelIrq()));
      expect32("R2 model rdData", rdData, modelRead(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wrEn = 1'b0;
    #1 d = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    idle(2);
    // R1 reset state
    #1;
    expect32("R1 irq after reset", 32'(irqOut), 0);
    expect32("R1 mask after reset", rdData, 0);
    rstN = 1'b1;
    rd(4'd4, v); expect32("R1 pendRise after reset", v, 0);
    rd(4'd6, v); expect32("R1 select after reset", v, 0);

    // R2 upper bits ignored
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, v); expect32("R2 mask upper bits", v, 32'h0000_FFFF);

    // R3 latency on line 0
    wr(4'd1, 32'h0000_0001);
    @(negedge clk); gpioIn[0] = 1'b1;
    rd(4'd4, v); expect32("R3 not yet after 1 edge", v, 0);
    rd(4'd4, v); expect32("R3 not yet after 2 edges", v, 0);
    rd(4'd4, v); expect32("R3 set after 3 edges", v, 32'h1);
    expect32("R9 irq0 unmasked", 32'(irqOut[0]), 1);

    // R4 falling edge with only rising enabled
    gpioIn[0] = 1'b0; idle(4);
    rd(4'd5, v); expect32("R4 fall ignored when disabled", v, 0);

    // R4/R5 both edges on line 1
    wr(4'd1, 32'h0000_0003);
    wr(4'd2, 32'h0000_0002);
    gpioIn[1] = 1'b1; idle(4);
    gpioIn[1] = 1'b0; idle(4);
    rd(4'd4, v); expect32("R4 rise latched line1", v, 32'h3);
    rd(4'd5, v); expect32("R5 fall separate reg", v, 32'h2);
    expect32("R5 irq1 from either", 32'(irqOut[1]), 1);

    // R6 write-1-to-clear
    wr(4'd4, 32'h0);
    rd(4'd4, v); expect32("R6 write 0 keeps", v, 32'h3);
    wr(4'd4, 32'h1);
    rd(4'd4, v); expect32("R6 write 1 clears", v, 32'h2);

    // R9 mask keeps pending
    wr(4'd0, 32'h0000_FFFD);
    #1 expect32("R9 irq1 masked", 32'(irqOut[1]), 0);
    rd(4'd5, v); expect32("R9 pending kept under mask", v, 32'h2);
    wr(4'd0, 32'h0000_FFFF);

    // R8 software trigger and R10 grouping
    wr(4'd4, 32'hFFFF); wr(4'd5, 32'hFFFF);
    wr(4'd3, 32'h0000_0080);
    rd(4'd4, v); expect32("R8 sw sets rise pending", v, 32'h80);
    expect32("R10 line7 on out5", 32'(irqOut), 32'h20);
    rd(4'd3, v); expect32("R2 sw reads zero", v, 0);
    wr(4'd3, 32'h0000_1000);
    #1 expect32("R10 line12 on out6", 32'(irqOut), 32'h60);
    wr(4'd4, 32'hFFFF);
    #1 expect32("R10 cleared all", 32'(irqOut), 0);

    // R11 port select for line 3 -> port 5
    wr(4'd6, 32'h0500_0000);
    rd(4'd6, v); expect32("R11 select readback", v, 32'h0500_0000);
    wr(4'd1, 32'h0000_0018);
    gpioIn[3] = 1'b1; idle(4);
    rd(4'd4, v); expect32("R11 unselected pin ignored", v, 0);
    gpioIn[5*16+3] = 1'b1; idle(4);
    rd(4'd4, v); expect32("R11 selected pin latched", v, 32'h8);
    wr(4'd4, 32'hFFFF);

    // R12 select change without spurious edge, line 2
    wr(4'd1, 32'h0000_001C);
    wr(4'd2, 32'h0000_0004);
    gpioIn[2*16+2] = 1'b1; idle(4);
    wr(4'd6, 32'h0502_0000);
    idle(3);
    rd(4'd4, v); expect32("R12 no rise on select change", v, 0);
    rd(4'd5, v); expect32("R12 no fall on select change", v, 0);
    gpioIn[2*16+2] = 1'b0; idle(4);
    rd(4'd5, v); expect32("R12 new pin edge seen", v, 32'h4);
    wr(4'd5, 32'hFFFF);

    // R7 edge and clear on the same clock edge, line 4
    @(negedge clk); gpioIn[4] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 4'd4; wrData = 32'h10; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    #1 expect32("R7 event survives clear", rdData, 32'h10);
    wr(4'd4, 32'h10);
    rd(4'd4, v); expect32("R7 later clear works", v, 0);

    idle(2);
    finishRun();
  end
endmodule